// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags and Equality Test

This block is an 8-bit arithmetic datapath that adds or subtracts two operands and derives four condition flags from the operation: negative (N), zero (Z), carry (C) and signed overflow (V). The arithmetic result is combinational. The flags are captured in a register on a clock edge when the flag-set enable is high, so that a later instruction can test them.

A compare operation subtracts the second operand from the first and keeps only the flags. The result output reads zero during a compare. A small condition evaluator reads the stored flags and reports whether an equal branch or a not-equal branch would be taken. Carry and signed overflow come from separate logic: the carry is the unsigned carry out of the top bit, and the overflow is a sign test on the operands and the result.

Top module: `nzcv_alu`

## Requirements
- R1: With opcode 2'b00 (add), `result` equals (op_a + op_b) mod 256 in the same cycle.
- R2: With opcode 2'b01 (subtract), `result` equals (op_a - op_b) mod 256. The C flag that is captured is 1 exactly when no borrow occurs (op_a >= op_b unsigned), because it is computed as op_a + ~op_b + 1.
- R3: The captured V is 1 only when the two effective addends (op_a and op_b for add, op_a and ~op_b for subtract/compare) have the same sign and the sign of the result differs from it. An add of operands of opposite sign never sets V.
- R4: The captured N equals bit 7 of the arithmetic result. The captured Z is 1 exactly when all 8 bits of the arithmetic result are zero.
- R5: For an add, the captured C is the carry out of bit 7. Examples: 0x7F+0x01 gives 0x80 with N=1,Z=0,C=0,V=1. 0x80+0xFF gives 0x7F with C=1,V=1. 0xFF+0x02 gives 0x01 with C=1,V=0. 0x05+0xFB gives 0x00 with Z=1,C=1.
- R6: With opcode 2'b10 (compare), `result` reads 0x00. The flags captured are those of op_a - op_b, so Z=1 exactly when the operands are equal.
- R7: The flags are loaded on a rising clock edge only when `set_flags` is 1 and the opcode is not 2'b11. Otherwise they hold their values.
- R8: `cond_eq` equals the stored Z flag, and `cond_ne` is its complement.
- R9: A synchronous active-high `rst` clears all four flags to 0, so that `cond_eq`=0 and `cond_ne`=1.
- R10: Opcode 2'b11 is reserved. It drives `result` to 0x00 and never changes the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| opcode | input | 2 | 00 add, 01 subtract, 10 compare, 11 reserved |
| set_flags | input | 1 | Capture flags at the next rising edge |
| result | output | 8 | Combinational arithmetic result |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry / no-borrow flag |
| flag_v | output | 1 | Stored signed overflow flag |
| cond_eq | output | 1 | Equal condition holds |
| cond_ne | output | 1 | Not-equal condition holds |

## Verification
The assertions assume that the operands, the opcode and `set_flags` are stable and known around each rising edge. They also assume that reset is held for at least one edge before any flag comparison is relied on. The stimulus changes inputs only on the falling edge and keeps every input at a defined 0/1 value. It asserts reset for several edges at the start. It mixes directed sign-boundary vectors with random operands, random opcodes that include the reserved code, and random `set_flags`, so that the hold and reserved-code properties are reached.

// File: rtl/nzcv_alu_pkg.sv
package nzcv_alu_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_CMP = 2'b10,
        OP_RSV = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic logic uses_inverted_b(alu_op_e op);
        return (op == OP_SUB) || (op == OP_CMP);
    endfunction

    function automatic logic writes_result(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import nzcv_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res_out,
    output flags_t       nxt_flags,
    output logic         op_valid
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   wide;
    logic [W-1:0] sum;

    always_comb begin
        cin   = uses_inverted_b(op);
        b_eff = cin ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        sum   = wide[W-1:0];

        nxt_flags.n = sum[MSB];
        nxt_flags.z = (sum == '0);
        nxt_flags.c = wide[W];
        nxt_flags.v = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);

        res_out  = writes_result(op) ? sum : '0;
        op_valid = (op != OP_RSV);
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import nzcv_alu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t d,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= FLAGS_CLEAR;
        else if (load) q <= d;
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
    import nzcv_alu_pkg::*;
(
    input  flags_t f,
    output logic   eq,
    output logic   ne
);
    always_comb begin
        eq = f.z;
        ne = ~f.z;
    end
endmodule

// File: rtl/nzcv_alu.sv
module nzcv_alu
    import nzcv_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [1:0]   opcode,
    input  logic         set_flags,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v,
    output logic         cond_eq,
    output logic         cond_ne
);
    alu_op_e op;
    flags_t  nxt;
    flags_t  cur;
    logic    valid;

    assign op = alu_op_e'(opcode);

    alu_addsub #(.W(W)) u_arith (
        .a(op_a), .b(op_b), .op(op),
        .res_out(result), .nxt_flags(nxt), .op_valid(valid)
    );

    alu_flag_reg u_flags (
        .clk(clk), .rst(rst), .load(set_flags && valid), .d(nxt), .q(cur)
    );

    alu_cond u_cond (.f(cur), .eq(cond_eq), .ne(cond_ne));

    assign flag_n = cur.n;
    assign flag_z = cur.z;
    assign flag_c = cur.c;
    assign flag_v = cur.v;
endmodule

// File: rtl/nzcv_alu_chk.sv
module nzcv_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [1:0]   opcode,
    input logic         set_flags,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_c,
    input logic         flag_v,
    input logic         cond_eq,
    input logic         cond_ne
);
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!set_flags || opcode == 2'b11) |=>
            $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (set_flags && opcode == 2'b00 && op_a[W-1] != op_b[W-1]) |=> !flag_v);

    assert_cmp_result_R6: assert property (@(posedge clk) disable iff (rst)
        (opcode == 2'b10) |-> (result == '0));

    assert_cmp_equal_R6: assert property (@(posedge clk) disable iff (rst)
        (set_flags && opcode == 2'b10 && op_a == op_b) |=> (flag_z && flag_c));

    assert_cond_R8: assert property (@(posedge clk) disable iff (rst)
        (cond_eq == flag_z) && (cond_ne != cond_eq));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

    assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        (opcode == 2'b11) |-> (result == '0));
endmodule

bind nzcv_alu nzcv_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .set_flags(set_flags), .result(result), .flag_n(flag_n),
    .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .cond_eq(cond_eq), .cond_ne(cond_ne)
);

// File: tb/sim_nzcv_alu.sv
module sim_nzcv_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [1:0] opcode = '0;
    logic       set_flags = 1'b0;
    logic [7:0] result;
    logic       flag_n, flag_z, flag_c, flag_v, cond_eq, cond_ne;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_n = 0, m_z = 0, m_c = 0, m_v = 0;

    always #10 clk = ~clk;

    nzcv_alu u0 (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .set_flags(set_flags), .result(result), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .cond_eq(cond_eq), .cond_ne(cond_ne)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_flags(string tag);
        chk({tag, " R4 N"}, flag_n, m_n);
        chk({tag, " R4 Z"}, flag_z, m_z);
        chk({tag, " R5/R2 C"}, flag_c, m_c);
        chk({tag, " R3 V"}, flag_v, m_v);
        chk({tag, " R8 eq"}, cond_eq, m_z);
        chk({tag, " R8 ne"}, cond_ne, 1 - m_z);
    endtask

    // One operation: drive on falling edge, check result, predict flags,
    // then check stored flags on the following falling edge (R7 hold included).
    task automatic step(int a, int b, int op, int sf);
        int s, res, c, v, sa, sb, sr;
        @(negedge clk);
        op_a = a[7:0]; op_b = b[7:0]; opcode = op[1:0]; set_flags = sf[0];
        #1;
        sa = (a >> 7) & 1;
        if (op == 0) begin
            s = a + b;
            sb = (b >> 7) & 1;
        end else begin
            s = a + (255 - b) + 1;
            sb = ((255 - b) >> 7) & 1;
        end
        res = s & 255;
        c = (s >> 8) & 1;
        sr = (res >> 7) & 1;
        v = (sa == sb && sr != sa) ? 1 : 0;
        if (op == 0)      chk("R1 add result", result, res);
        else if (op == 1) chk("R2 sub result", result, res);
        else if (op == 2) chk("R6 cmp result zero", result, 0);
        else              chk("R10 reserved result zero", result, 0);
        if (sf != 0 && op != 3) begin
            m_n = sr; m_z = (res == 0) ? 1 : 0; m_c = c; m_v = v;
        end
        @(negedge clk);
        if (sf == 0 || op == 3) check_flags("R7/R10 hold");
        else                    check_flags("update");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_n = 0; m_z = 0; m_c = 0; m_v = 0;
        check_flags("R9 reset");

        // R5 boundary vectors
        step(8'h7F, 8'h01, 0, 1);
        chk("R5 7F+01 N", flag_n, 1); chk("R5 7F+01 V", flag_v, 1);
        step(8'h80, 8'hFF, 0, 1);
        chk("R5 80+FF C", flag_c, 1); chk("R5 80+FF V", flag_v, 1);
        step(8'hFF, 8'h02, 0, 1);
        chk("R5 FF+02 C", flag_c, 1); chk("R3 FF+02 V", flag_v, 0);
        step(8'h05, 8'hFB, 0, 1);
        chk("R4 05+FB Z", flag_z, 1); chk("R8 eq taken", cond_eq, 1);
        // R6 compare equal / unequal, R2 borrow
        step(8'h05, 8'h05, 2, 1);
        chk("R6 cmp equal Z", flag_z, 1);
        step(8'h03, 8'h05, 2, 1);
        chk("R6 cmp unequal ne", cond_ne, 1); chk("R2 borrow C", flag_c, 0);
        step(8'h05, 8'h03, 1, 1);
        chk("R2 no-borrow C", flag_c, 1);
        step(8'h80, 8'h01, 1, 1);
        chk("R3 sub overflow V", flag_v, 1);
        // R7 / R10 hold
        step(8'h00, 8'h00, 0, 0);
        step(8'h00, 8'h00, 3, 1);

        for (int i = 0; i < 400; i++)
            step($urandom_range(0, 255), $urandom_range(0, 255),
                 $urandom_range(0, 3), $urandom_range(0, 1));

        // R9 reset mid-run
        step(8'hFF, 8'h01, 0, 1);
        @(negedge clk); rst = 1'b1; set_flags = 1'b0;
        @(negedge clk); rst = 1'b0;
        m_n = 0; m_z = 0; m_c = 0; m_v = 0;
        check_flags("R9 reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule